// File: doc/BRIEF.md
# Grouped interrupt flag/enable controller

This block collects sixteen asynchronous event inputs into four groups of four. Each group keeps a register of pending flags and a register of enable bits. A synchronized rising edge on a source input sets its flag. Software clears a flag by writing a one to its bit. The enable register is never overwritten as a whole. Bit 7 of the write data selects the operation: when it is 1 the write turns on the addressed bits, and when it is 0 it turns them off. Bits whose data bit is 0 keep their state, so a driver can change one source without first reading the register back.

A group requests service while any of its flags is set with the matching enable bit also set. The four groups map to processor interrupt levels 3, 4, 5 and 6. A small encoder also reports the highest requesting level on a 3-bit output, which reads 0 when no group is requesting.

The register bus is byte-wide, with separate write and read strobes. Group registers are spaced 0x10 apart. The upper address nibble carries the level number (3 to 6). Within a group, offset 0x0 holds the flags and offset 0x4 holds the enables.

Top module: `grpirq_ctrl`

## Requirements
- R1: After reset all flag bits and all enable bits are 0, every request line is 0 and the priority output is 0.
- R2: A write to an enable register (address level*0x10+0x4) with data bit 7 = 1 sets every enable bit whose data bit in [3:0] is 1. All other enable bits keep their value.
- R3: A write to an enable register with data bit 7 = 0 clears every enable bit whose data bit in [3:0] is 1. All other enable bits keep their value.
- R4: A write to a flag register (address level*0x10+0x0) clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R5: A rising edge on source input g*4+i sets flag i of group g, which is served at level g+3. The flag is set a few clocks later, after the synchronizer. A source that stays high does not set its flag again after the flag has been cleared.
- R6: When a source edge and a software clear of the same flag act in the same clock, the flag ends up set.
- R7: Request bit g (interrupt level g+3) is 1 exactly when the flags of group g ANDed with its enables are non-zero.
- R8: The priority output equals the highest level among 3 to 6 whose group is requesting, or 0 when no group is requesting.
- R9: Read data is registered and is valid on the clock after the read strobe. Bits [3:0] return the addressed register and bits [7:4] are 0. An unmapped address reads 0x00.
- R10: Writing 0x0F to every enable register and then 0x0F to every flag register leaves all enables and all flags at 0 and no request active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid one clock after the read strobe |
| src_in | input | 16 | Event inputs; bit g*4+i is source i of group g |
| irq_req | output | 4 | Request per group; bit g is interrupt level g+3 |
| irq_level | output | 3 | Highest requesting level, 0 when idle |

## Verification
The assertions assume two things about the inputs. First, each bus strobe lasts exactly one clock per access. Second, a source input is treated as asynchronous and only its synchronized edges matter. The set-wins property also assumes that software clears never outrun edges it has not seen yet. The stimulus changes bus signals only on falling clock edges and holds each strobe for a single cycle. Sources are pulsed high and low with several idle clocks on each side, so every edge passes the synchronizer before the bench updates its model. A single directed case lines up an edge with a clear in the same clock.

// File: rtl/grpirq_pkg.sv
package grpirq_pkg;
   // Within-group register offsets (low address nibble)
   localparam int unsigned FLAG_OFS = 0;
   localparam int unsigned EN_OFS   = 4;
   // Data bit that selects set (1) or clear (0) for enable writes
   localparam int unsigned MODE_BIT = 7;

   typedef enum logic [1:0] {
      REG_NONE = 2'd0,
      REG_FLAG = 2'd1,
      REG_EN   = 2'd2
   } reg_kind_e;
endpackage

// File: rtl/grpirq_edge.sv
module grpirq_edge #(
   parameter int unsigned N           = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_in,
   output logic [N-1:0] rise
);
   logic [N-1:0] synced;
   logic [N-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign synced = src_in;
      end else begin : g_chain
         logic [N-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= src_in;
               for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign synced = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   assign rise = synced & ~prev_q;

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((rise & $past(rise)) == '0)); // R5
endmodule

// File: rtl/grpirq_group.sv
module grpirq_group
   import grpirq_pkg::*;
#(
   parameter int unsigned SRCS   = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRCS-1:0]   set_ev,
   input  logic              en_wr,
   input  logic              fl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [SRCS-1:0]   flag_q,
   output logic [SRCS-1:0]   en_q,
   output logic              req
);
   logic [SRCS-1:0] sel;
   logic            mode_set;

   assign sel      = wdata[SRCS-1:0];
   assign mode_set = wdata[MODE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr) begin
         if (mode_set) en_q <= en_q | sel;
         else          en_q <= en_q & ~sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= ((fl_wr ? (flag_q & ~sel) : flag_q)) | set_ev;
      end
   end

   assign req = |(flag_q & en_q);

   AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_q)); // R2
   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && wdata[MODE_BIT]) |=> ((en_q & $past(sel)) == $past(sel))); // R2
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !wdata[MODE_BIT]) |=> ((en_q & $past(sel)) == '0)); // R3
   AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_wr && set_ev == '0) |=> ((flag_q & $past(sel)) == '0)); // R4
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev != '0) |=> ((flag_q & $past(set_ev)) == $past(set_ev))); // R6
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_wr && set_ev == '0) |=> $stable(flag_q)); // R4
endmodule

// File: rtl/grpirq_prio.sv
module grpirq_prio #(
   parameter int unsigned GROUPS     = 4,
   parameter int unsigned BASE_LEVEL = 3,
   parameter int unsigned LVL_W      = 3
) (
   input  logic [GROUPS-1:0] req,
   output logic [LVL_W-1:0]  level
);
   always_comb begin
      level = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (req[g]) level = LVL_W'(BASE_LEVEL + g);
      end
   end

   always_comb begin
      if (req == '0) AST_IDLE_ZERO: assert (level == '0); // R8
      else AST_TOP_ACTIVE: assert (level >= LVL_W'(BASE_LEVEL)
                                   && req[level - LVL_W'(BASE_LEVEL)]
                                   && (req >> (level - LVL_W'(BASE_LEVEL) + 1)) == '0); // R8
   end
endmodule

// File: rtl/grpirq_ctrl.sv
module grpirq_ctrl
   import grpirq_pkg::*;
#(
   parameter int unsigned GROUPS      = 4,
   parameter int unsigned SRCS        = 4,
   parameter int unsigned BASE_LEVEL  = 3,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LVL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NSRC       = GROUPS * SRCS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   src_in,
   output logic [GROUPS-1:0] irq_req,
   output logic [LVL_W-1:0]  irq_level
);
   localparam int unsigned HI_W = ADDR_W - 4;

   generate
      if (SRCS > MODE_BIT) begin : g_bad_srcs
         $error("SRCS must leave the mode bit free");
      end
      if (DATA_W <= MODE_BIT) begin : g_bad_data
         $error("DATA_W must hold the mode bit");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if ((BASE_LEVEL + GROUPS - 1) >= (1 << LVL_W)) begin : g_bad_lvl
         $error("LVL_W too narrow for the highest level");
      end
      if ((BASE_LEVEL + GROUPS - 1) >= (1 << HI_W)) begin : g_bad_map
         $error("address too narrow for the level field");
      end
   endgenerate

   logic [NSRC-1:0] rise;

   grpirq_edge #(.N(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .rise(rise)
   );

   // Address decode
   logic [HI_W-1:0] hi;
   logic [3:0]      lo;
   reg_kind_e       kind;

   assign hi = bus_addr[ADDR_W-1:4];
   assign lo = bus_addr[3:0];

   always_comb begin
      unique case (lo)
         4'(FLAG_OFS): kind = REG_FLAG;
         4'(EN_OFS):   kind = REG_EN;
         default:      kind = REG_NONE;
      endcase
   end

   logic [GROUPS-1:0] hit;
   logic [SRCS-1:0]   flags [GROUPS];
   logic [SRCS-1:0]   ens   [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign hit[g] = (hi == HI_W'(BASE_LEVEL + g));

      grpirq_group #(.SRCS(SRCS), .DATA_W(DATA_W)) u_grp (
         .clk   (clk),
         .rst_n (rst_n),
         .set_ev(rise[g*SRCS +: SRCS]),
         .en_wr (bus_wr && hit[g] && kind == REG_EN),
         .fl_wr (bus_wr && hit[g] && kind == REG_FLAG),
         .wdata (bus_wdata),
         .flag_q(flags[g]),
         .en_q  (ens[g]),
         .req   (irq_req[g])
      );
   end

   // Read path
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (hit[g]) begin
            if (kind == REG_FLAG)    rd_mux[SRCS-1:0] = flags[g];
            else if (kind == REG_EN) rd_mux[SRCS-1:0] = ens[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   grpirq_prio #(.GROUPS(GROUPS), .BASE_LEVEL(BASE_LEVEL), .LVL_W(LVL_W)) u_prio (
      .req(irq_req), .level(irq_level)
   );

   always_comb begin
      AST_RD_UPPER_ZERO: assert (!rst_n || bus_rdata[DATA_W-1:SRCS] == '0); // R9
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R9
   AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req == '0) |-> (irq_level == '0)); // R8
endmodule

// File: tb/grpirq_ctrl_test.sv
module grpirq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [15:0] src_in = '0;
   logic [3:0]  irq_req;
   logic [2:0]  irq_level;

   int checks = 0;
   int fails  = 0;
   logic [3:0] m_flag [4];
   logic [3:0] m_en   [4];

   always #5 clk = ~clk;

   grpirq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .src_in(src_in), .irq_req(irq_req), .irq_level(irq_level)
   );

   function automatic logic [7:0] flag_addr(int g);
      return 8'(((g + 3) << 4) | 0);
   endfunction
   function automatic logic [7:0] en_addr(int g);
      return 8'(((g + 3) << 4) | 4);
   endfunction
   function automatic logic [3:0] exp_req();
      logic [3:0] r;
      for (int g = 0; g < 4; g++) r[g] = |(m_flag[g] & m_en[g]);
      return r;
   endfunction
   function automatic logic [2:0] exp_level();
      logic [3:0] r;
      logic [2:0] l;
      r = exp_req();
      l = 3'd0;
      for (int g = 0; g < 4; g++) if (r[g]) l = 3'(g + 3);
      return l;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic en_write(int g, logic [7:0] d);
      bus_write(en_addr(g), d);
      if (d[7]) m_en[g] = m_en[g] | d[3:0];
      else      m_en[g] = m_en[g] & ~d[3:0];
   endtask

   task automatic flag_write(int g, logic [7:0] d);
      bus_write(flag_addr(g), d);
      m_flag[g] = m_flag[g] & ~d[3:0];
   endtask

   task automatic pulse_src(int idx);
      @(negedge clk);
      src_in[idx] = 1'b1;
      repeat (5) @(negedge clk);
      m_flag[idx / 4][idx % 4] = 1'b1;
      src_in[idx] = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic check_group(string req, int g);
      logic [7:0] d;
      bus_read(flag_addr(g), d);
      check(req, d, {4'h0, m_flag[g]});
      bus_read(en_addr(g), d);
      check(req, d, {4'h0, m_en[g]});
   endtask

   task automatic check_irq(string req);
      check({req, " req"}, {4'h0, irq_req}, {4'h0, exp_req()});
      check({req, " level"}, {5'h0, irq_level}, {5'h0, exp_level()});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      void'($urandom(32'h5EED_1234));
      for (int g = 0; g < 4; g++) begin m_flag[g] = '0; m_en[g] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int g = 0; g < 4; g++) check_group("R1", g);
      check_irq("R1");

      // R2 / R3: set and clear modes, untouched bits kept
      en_write(0, 8'h85); check_group("R2", 0);
      en_write(0, 8'h82); check_group("R2", 0);
      en_write(0, 8'h04); check_group("R3", 0);
      en_write(0, 8'h00); check_group("R3", 0);

      // R5 / R7 / R8: edge sets flag, request and level follow
      pulse_src(1); check_group("R5", 0); check_irq("R7");
      pulse_src(13); check_group("R5", 3); check_irq("R8");
      en_write(3, 8'h82); check_irq("R8");
      en_write(2, 8'h81); pulse_src(8); check_irq("R8");

      // R4: write-one-to-clear, zero bits untouched
      pulse_src(0); flag_write(0, 8'h01); check_group("R4", 0); check_irq("R7");

      // R5: held-high source does not re-set after clear
      @(negedge clk); src_in[6] = 1'b1;
      repeat (5) @(negedge clk);
      m_flag[1][2] = 1'b1;
      flag_write(1, 8'h04);
      repeat (5) @(negedge clk);
      check_group("R5", 1);
      src_in[6] = 1'b0;
      repeat (5) @(negedge clk);

      // R6: edge and clear act in the same clock
      @(negedge clk); src_in[11] = 1'b1;
      repeat (2) @(negedge clk);
      bus_addr = flag_addr(2); bus_wdata = 8'h08; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      m_flag[2][3] = 1'b1;
      repeat (3) @(negedge clk);
      src_in[11] = 1'b0;
      repeat (5) @(negedge clk);
      check_group("R6", 2);

      // R9: unmapped addresses read zero, upper bits zero
      bus_read(8'h34, d); check("R9", d, {4'h0, m_en[0]});
      bus_read(8'h38, d); check("R9", d, 8'h00);
      bus_read(8'h20, d); check("R9", d, 8'h00);
      bus_read(8'h70, d); check("R9", d, 8'h00);
      bus_write(8'h74, 8'h8F); check_irq("R9");

      // Random mix
      for (int it = 0; it < 300; it++) begin
         int op = $urandom_range(0, 3);
         int g  = $urandom_range(0, 3);
         logic [7:0] rd = 8'($urandom);
         case (op)
            0: en_write(g, rd);
            1: flag_write(g, rd);
            2: pulse_src($urandom_range(0, 15));
            default: check_group("R2", g);
         endcase
         check_irq("R7");
      end

      // R10: init sequence masks and clears everything
      for (int g = 0; g < 4; g++) en_write(g, 8'h0F);
      for (int g = 0; g < 4; g++) flag_write(g, 8'h0F);
      for (int g = 0; g < 4; g++) begin
         check_group("R10", g);
         check("R10", {4'h0, m_en[g] | m_flag[g]}, 8'h00);
      end
      check_irq("R10");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule